// File: doc/BRIEF.md
# Variable Sample Rate Strobe Generator

This block turns a fixed 48 kHz frame tick into per-frame sample-request strobes for four audio paths: left and right ADC and left and right DAC. Two rate generators each take a 16-bit rate in hertz with 1 Hz resolution. Each generator keeps a phase accumulator. The accumulator advances by the generator's effective rate on every frame tick. Whenever the accumulator passes the frame rate, the generator raises a strobe. Each of the four paths has its own select bit, which chooses the generator that paces it.

The second generator can scale its rate by 8/7 or by 10/7. These multipliers let a rate derived from a 48 kHz base land on rates built from other bases. The result is always capped at the frame rate, so a generator never asks for more than one sample in a frame.

Each DAC path takes samples over a valid/ready stream interface. Ready is high only in the cycle of that path's strobe, and a sample is taken when valid and ready are both high. The upstream source may hold valid high with stable data for as long as it likes; nothing is taken until the next strobe. If a strobe finds valid low, the path is starved. A control input then chooses whether the held sample is replaced by zero or kept and repeated.

Top module: `vsr_strobe_gen`

## Requirements
- R1: After reset, all strobes and ready outputs are low and both held DAC samples are zero. Both generators start at 48000 Hz, so the first frame tick raises all four strobes.
- R2: A strobe lasts one clock cycle and appears in the cycle right after the frame tick that produced it. Over any 48000 consecutive ticks that follow a rate write, a generator produces exactly its effective rate in strobes.
- R3: A programmed rate below 7040 is treated as 7040, and a programmed rate above 48000 is treated as 48000.
- R4: When mul_8_7 is set, generator 1 runs at floor(clamped rate × 8 / 7). When mul_10_7 is set, it runs at floor(clamped rate × 10 / 7), and mul_10_7 wins if both bits are set. The result is capped at 48000.
- R5: Each path's select bit chooses its generator: 0 selects generator 0 and 1 selects generator 1. Paths that select the same generator strobe in the same cycles.
- R6: A rate write resets that generator's accumulator. On the first frame tick after the write, the sum starts from zero plus the new rate.
- R7: No strobe is raised in a cycle whose previous cycle had no frame tick.
- R8: A DAC path's ready output equals its strobe. In a cycle where ready and valid are both high, the data is held as that path's sample from the next cycle on.
- R9: When a strobe meets valid low, the held sample becomes zero if zero_fill is 1 and is kept unchanged if zero_fill is 0. The held sample never changes outside a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse per 48 kHz frame |
| rate0_val | input | 16 | Rate for generator 0 in Hz |
| rate0_wr | input | 1 | Loads rate0_val |
| rate1_val | input | 16 | Rate for generator 1 in Hz |
| rate1_wr | input | 1 | Loads rate1_val |
| mul_8_7 | input | 1 | Scales generator 1 by 8/7 |
| mul_10_7 | input | 1 | Scales generator 1 by 10/7 (has priority) |
| sel_adc_l | input | 1 | Generator select, left ADC |
| sel_adc_r | input | 1 | Generator select, right ADC |
| sel_dac_l | input | 1 | Generator select, left DAC |
| sel_dac_r | input | 1 | Generator select, right DAC |
| zero_fill | input | 1 | Starved DAC: 1 outputs zero, 0 repeats last sample |
| dacl_valid | input | 1 | Left DAC stream valid |
| dacl_data | input | 16 | Left DAC stream data |
| dacr_valid | input | 1 | Right DAC stream valid |
| dacr_data | input | 16 | Right DAC stream data |
| adc_l_stb | output | 1 | Left ADC sample strobe |
| adc_r_stb | output | 1 | Right ADC sample strobe |
| dac_l_stb | output | 1 | Left DAC sample strobe |
| dac_r_stb | output | 1 | Right DAC sample strobe |
| dacl_ready | output | 1 | Left DAC stream ready |
| dacr_ready | output | 1 | Right DAC stream ready |
| dacl_sample | output | 16 | Held left DAC sample |
| dacr_sample | output | 16 | Held right DAC sample |

## Verification
If an accumulator holds a wrong value, strobes land on the wrong frames. The error shows up within a few ticks as a strobe in the wrong cycle. Over a full second of ticks it also shows up as a wrong strobe count, so counting against every clamp and multiplier case exposes both step errors and lost remainders. If a rate write fails to clear the accumulator, the first tick after the write produces an extra strobe. A wrong sample register shows on the sample port one cycle after the strobe in question, whether the strobe took new data, filled zero or repeated the old sample.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  typedef enum logic [1:0] {
    CH_ADC_L = 2'd0,
    CH_ADC_R = 2'd1,
    CH_DAC_L = 2'd2,
    CH_DAC_R = 2'd3
  } vsr_chan_e;

  localparam int NUM_GEN = 2;
  localparam int NUM_CH  = 4;
  localparam int NUM_DAC = 2;
endpackage

// File: rtl/vsr_rate_shaper.sv
module vsr_rate_shaper #(
  parameter int RATE_W   = 16,
  parameter int FRAME_HZ = 48000,
  parameter int MIN_HZ   = 7040,
  parameter bit HAS_MUL  = 1'b0
) (
  input  logic [RATE_W-1:0] rate_in,
  input  logic              mul_8_7,
  input  logic              mul_10_7,
  output logic [RATE_W-1:0] rate_eff
);
  localparam int WW = RATE_W + 4;
  localparam logic [RATE_W-1:0] LO   = RATE_W'(MIN_HZ);
  localparam logic [RATE_W-1:0] HI   = RATE_W'(FRAME_HZ);
  localparam logic [WW-1:0]     HI_W = WW'(FRAME_HZ);

  logic [RATE_W-1:0] clamped;
  logic [WW-1:0]     wide;
  logic [WW-1:0]     scaled;

  always_comb begin
    if (rate_in < LO)      clamped = LO;
    else if (rate_in > HI) clamped = HI;
    else                   clamped = rate_in;
  end

  assign wide = {4'b0000, clamped};

  generate
    if (HAS_MUL) begin : g_mul
      always_comb begin
        if (mul_10_7)     scaled = (wide * WW'(10)) / WW'(7);
        else if (mul_8_7) scaled = (wide * WW'(8)) / WW'(7);
        else              scaled = wide;
      end
    end else begin : g_plain
      logic unused_mul;
      assign unused_mul = mul_8_7 ^ mul_10_7;
      assign scaled = wide;
    end
  endgenerate

  assign rate_eff = (scaled > HI_W) ? HI : scaled[RATE_W-1:0];
endmodule

// File: rtl/vsr_phase_acc.sv
module vsr_phase_acc #(
  parameter int RATE_W   = 16,
  parameter int FRAME_HZ = 48000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              restart,
  input  logic [RATE_W-1:0] step,
  output logic              stb
);
  localparam int AW = $clog2(2 * FRAME_HZ);
  localparam logic [AW-1:0] FR = AW'(FRAME_HZ);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] base;
  logic [AW-1:0] sum;
  logic          pend_q;

  always_comb begin
    base = pend_q ? '0 : acc_q;
    sum  = base + AW'(step);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pend_q <= 1'b0;
      stb    <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (frame_tick) begin
        pend_q <= 1'b0;
        if (sum >= FR) begin
          acc_q <= sum - FR;
          stb   <= 1'b1;
        end else begin
          acc_q <= sum;
        end
      end
      if (restart) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/vsr_dac_fill.sv
module vsr_dac_fill #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb,
  input  logic                zero_fill,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                in_ready,
  output logic [SAMPLE_W-1:0] sample
);
  assign in_ready = stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample <= '0;
    end else if (stb) begin
      if (in_valid)       sample <= in_data;
      else if (zero_fill) sample <= '0;
    end
  end
endmodule

// File: rtl/vsr_strobe_gen.sv
module vsr_strobe_gen #(
  parameter int RATE_W   = 16,
  parameter int SAMPLE_W = 16,
  parameter int FRAME_HZ = 48000,
  parameter int MIN_HZ   = 7040
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_tick,
  input  logic [RATE_W-1:0]   rate0_val,
  input  logic                rate0_wr,
  input  logic [RATE_W-1:0]   rate1_val,
  input  logic                rate1_wr,
  input  logic                mul_8_7,
  input  logic                mul_10_7,
  input  logic                sel_adc_l,
  input  logic                sel_adc_r,
  input  logic                sel_dac_l,
  input  logic                sel_dac_r,
  input  logic                zero_fill,
  input  logic                dacl_valid,
  input  logic [SAMPLE_W-1:0] dacl_data,
  input  logic                dacr_valid,
  input  logic [SAMPLE_W-1:0] dacr_data,
  output logic                adc_l_stb,
  output logic                adc_r_stb,
  output logic                dac_l_stb,
  output logic                dac_r_stb,
  output logic                dacl_ready,
  output logic                dacr_ready,
  output logic [SAMPLE_W-1:0] dacl_sample,
  output logic [SAMPLE_W-1:0] dacr_sample
);
  import vsr_pkg::*;

  localparam logic [RATE_W-1:0] RATE_RST = RATE_W'(FRAME_HZ);

  logic [RATE_W-1:0]   rate_in  [NUM_GEN];
  logic                rate_wr  [NUM_GEN];
  logic [RATE_W-1:0]   rate_q   [NUM_GEN];
  logic [RATE_W-1:0]   rate_eff [NUM_GEN];
  logic [NUM_GEN-1:0]  gen_stb;
  logic [NUM_CH-1:0]   ch_sel;
  logic [NUM_CH-1:0]   ch_stb;
  logic [NUM_DAC-1:0]  dv;
  logic [SAMPLE_W-1:0] dd [NUM_DAC];
  logic [NUM_DAC-1:0]  dr;
  logic [SAMPLE_W-1:0] ds [NUM_DAC];

  assign rate_in[0] = rate0_val;
  assign rate_in[1] = rate1_val;
  assign rate_wr[0] = rate0_wr;
  assign rate_wr[1] = rate1_wr;

  genvar g;
  generate
    for (g = 0; g < NUM_GEN; g++) begin : g_gen
      always_ff @(posedge clk) begin
        if (!rst_n)          rate_q[g] <= RATE_RST;
        else if (rate_wr[g]) rate_q[g] <= rate_in[g];
      end

      vsr_rate_shaper #(
        .RATE_W(RATE_W), .FRAME_HZ(FRAME_HZ), .MIN_HZ(MIN_HZ),
        .HAS_MUL(g == 1)
      ) u_shape (
        .rate_in(rate_q[g]), .mul_8_7(mul_8_7), .mul_10_7(mul_10_7),
        .rate_eff(rate_eff[g])
      );

      vsr_phase_acc #(.RATE_W(RATE_W), .FRAME_HZ(FRAME_HZ)) u_acc (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .restart(rate_wr[g]), .step(rate_eff[g]), .stb(gen_stb[g])
      );
    end
  endgenerate

  assign ch_sel[CH_ADC_L] = sel_adc_l;
  assign ch_sel[CH_ADC_R] = sel_adc_r;
  assign ch_sel[CH_DAC_L] = sel_dac_l;
  assign ch_sel[CH_DAC_R] = sel_dac_r;

  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      assign ch_stb[g] = gen_stb[ch_sel[g]];
    end
  endgenerate

  assign adc_l_stb = ch_stb[CH_ADC_L];
  assign adc_r_stb = ch_stb[CH_ADC_R];
  assign dac_l_stb = ch_stb[CH_DAC_L];
  assign dac_r_stb = ch_stb[CH_DAC_R];

  assign dv[0] = dacl_valid;
  assign dv[1] = dacr_valid;
  assign dd[0] = dacl_data;
  assign dd[1] = dacr_data;

  generate
    for (g = 0; g < NUM_DAC; g++) begin : g_dac
      vsr_dac_fill #(.SAMPLE_W(SAMPLE_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .stb(ch_stb[CH_DAC_L + g]),
        .zero_fill(zero_fill), .in_valid(dv[g]), .in_data(dd[g]),
        .in_ready(dr[g]), .sample(ds[g])
      );
    end
  endgenerate

  assign dacl_ready  = dr[0];
  assign dacr_ready  = dr[1];
  assign dacl_sample = ds[0];
  assign dacr_sample = ds[1];
endmodule

// File: rtl/vsr_strobe_gen_chk.sv
module vsr_strobe_gen_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_tick,
  input logic                sel_adc_l,
  input logic                sel_dac_l,
  input logic                zero_fill,
  input logic                adc_l_stb,
  input logic                adc_r_stb,
  input logic                dac_l_stb,
  input logic                dac_r_stb,
  input logic                dacl_ready,
  input logic                dacl_valid,
  input logic [SAMPLE_W-1:0] dacl_data,
  input logic [SAMPLE_W-1:0] dacl_sample
);
  // R7: every strobe is preceded by a frame tick
  p_stb_follows_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_l_stb || adc_r_stb || dac_l_stb || dac_r_stb) |-> $past(frame_tick));

  // R5: two paths on the same generator strobe together
  p_same_gen_same_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_adc_l == sel_dac_l) |-> (adc_l_stb == dac_l_stb));

  // R8: an accepted beat becomes the held sample
  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dacl_ready && dacl_valid) |=> (dacl_sample == $past(dacl_data)));

  // R9: starved with zero fill gives zero
  p_zero_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_l_stb && !dacl_valid && zero_fill) |=> (dacl_sample == '0));

  // R9: starved without zero fill repeats
  p_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_l_stb && !dacl_valid && !zero_fill) |=> $stable(dacl_sample));

  // R9: held sample is quiet outside strobes
  p_quiet_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_l_stb |=> $stable(dacl_sample));
endmodule

bind vsr_strobe_gen vsr_strobe_gen_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
  .sel_adc_l(sel_adc_l), .sel_dac_l(sel_dac_l), .zero_fill(zero_fill),
  .adc_l_stb(adc_l_stb), .adc_r_stb(adc_r_stb), .dac_l_stb(dac_l_stb),
  .dac_r_stb(dac_r_stb), .dacl_ready(dacl_ready), .dacl_valid(dacl_valid),
  .dacl_data(dacl_data), .dacl_sample(dacl_sample)
);

// File: tb/tb_vsr_strobe_gen.sv
module tb_vsr_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic [15:0] rate0_val = '0, rate1_val = '0;
  logic        rate0_wr = 1'b0, rate1_wr = 1'b0;
  logic        mul_8_7 = 1'b0, mul_10_7 = 1'b0;
  logic        sel_adc_l = 1'b0, sel_adc_r = 1'b0, sel_dac_l = 1'b0, sel_dac_r = 1'b0;
  logic        zero_fill = 1'b0;
  logic        dacl_valid = 1'b0, dacr_valid = 1'b0;
  logic [15:0] dacl_data = '0, dacr_data = '0;
  logic        adc_l_stb, adc_r_stb, dac_l_stb, dac_r_stb, dacl_ready, dacr_ready;
  logic [15:0] dacl_sample, dacr_sample;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vsr_strobe_gen dut (.*);

  localparam int NV = 3;
  localparam int T_R0[NV]  = '{44100, 5000, 60000};
  localparam int T_R1[NV]  = '{8000, 22050, 40000};
  localparam int T_M8[NV]  = '{0, 1, 1};
  localparam int T_M10[NV] = '{0, 0, 1};
  localparam int T_E0[NV]  = '{44100, 7040, 48000};
  localparam int T_E1[NV]  = '{8000, 25200, 48000};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_rates(input bit w0, input int r0, input bit w1, input int r1);
    rate0_val = 16'(r0); rate1_val = 16'(r1);
    rate0_wr = w0; rate1_wr = w1;
    @(negedge clk);
    rate0_wr = 1'b0; rate1_wr = 1'b0;
  endtask

  task automatic one_tick();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes low", int'(adc_l_stb | adc_r_stb | dac_l_stb | dac_r_stb), 0);
    chk("R1 ready low", int'(dacl_ready | dacr_ready), 0);
    chk("R1 samples zero", int'(dacl_sample | dacr_sample), 0);
    one_tick();
    chk("R1 default rate strobes all", int'({adc_l_stb, adc_r_stb, dac_l_stb, dac_r_stb}), 15);
    @(negedge clk);
    chk("R7 no strobe without tick", int'(adc_l_stb | adc_r_stb | dac_l_stb | dac_r_stb), 0);

    // R2 R3 R4: table of rate vectors, counting over 48000 ticks
    sel_adc_l = 1'b0; sel_adc_r = 1'b1;
    for (int v = 0; v < NV; v++) begin
      int c0, c1;
      c0 = 0; c1 = 0;
      mul_8_7 = T_M8[v][0]; mul_10_7 = T_M10[v][0];
      write_rates(1'b1, T_R0[v], 1'b1, T_R1[v]);
      frame_tick = 1'b1;
      for (int i = 0; i < 48000; i++) begin
        @(negedge clk);
        c0 += int'(adc_l_stb);
        c1 += int'(adc_r_stb);
      end
      frame_tick = 1'b0;
      @(negedge clk);
      chk($sformatf("R2 R3 gen0 count vec%0d", v), c0, T_E0[v]);
      chk($sformatf("R2 R4 gen1 count vec%0d", v), c1, T_E1[v]);
    end

    // R5 selectors
    mul_8_7 = 1'b0; mul_10_7 = 1'b0;
    sel_adc_l = 1'b1; sel_adc_r = 1'b0; sel_dac_l = 1'b0; sel_dac_r = 1'b1;
    write_rates(1'b1, 48000, 1'b1, 24000);
    one_tick();
    chk("R5 selector pattern", int'({adc_l_stb, adc_r_stb, dac_l_stb, dac_r_stb}), 4'b0110);

    // R6 write clears accumulator (gen1 holds 24000 now)
    write_rates(1'b0, 48000, 1'b1, 24000);
    one_tick();
    chk("R6 cleared gen no strobe", int'(dac_r_stb), 0);
    one_tick();
    chk("R6 strobe on second tick", int'(dac_r_stb), 1);

    // R8 handshake and capture
    dacl_valid = 1'b1; dacl_data = 16'h1234;
    one_tick();
    chk("R8 ready with strobe", int'(dacl_ready), 1);
    @(negedge clk);
    chk("R8 ready low off strobe", int'(dacl_ready), 0);
    chk("R8 sample captured", int'(dacl_sample), 16'h1234);

    // R9 starved: repeat then zero
    dacl_valid = 1'b0; dacl_data = 16'hBEEF; zero_fill = 1'b0;
    one_tick();
    @(negedge clk);
    chk("R9 repeat on starve", int'(dacl_sample), 16'h1234);
    zero_fill = 1'b1;
    one_tick();
    @(negedge clk);
    chk("R9 zero fill on starve", int'(dacl_sample), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule